// File: doc/BRIEF.md
# CCD Clocking Program Sequencer

This block runs a clocking program stored in a 32K-word program memory. The program is a chain of blocks. Each block starts with a two-word header and is followed by a list of couplets. A couplet names one waveform-engine entry (an SRAM block address), gives a repeat count, and carries a pixel code. On every pixel-clock enable the sequencer emits one step. A step is the SRAM address for the waveform engine together with the pixel code for the downstream pixel processors. Steps are emitted on every pixel clock while the sequencer runs, including pixel clocks on which no real pixel is read out.

Execution has two levels. A couplet repeats for its own count. The block's couplets then run in order, and that whole group repeats for the block's count. When the last repetition ends, the header's end action decides what happens next: stop, carry on at the word after the couplets, restart at address 0, or jump to the first word of one of four 8192-word pages. A background fetch unit reads headers and couplets ahead of use, so block boundaries cost no pixel clocks. A control level `run` starts execution at address 0 when it rises and returns the block to idle when it falls.

The program memory has a one-cycle read latency: the word for the address shown in one cycle appears on `mem_rdata` in the next.

Top module: `ccd_prog_seq`

## Requirements
- R1: Word layout, selected by bits 15:14.
  - Header first word: tag 11, action in bits 13:12, block repeat in bits 11:0.
  - Header second word: tag 10, page in bits 13:12, couplet count in bits 11:0.
  - Couplet first word: tag 01, SRAM address in bits 13:3, pixel code in bits 2:0.
  - Couplet second word: tag 00, repeat in bits 13:0.
  - Execution starts at address 0 after `run` rises.
- R2: Each `pix_ce` pulse seen while running produces exactly one `seq_stb` pulse in the next cycle, carrying `seq_sram` and `seq_code`. A couplet is emitted on as many consecutive steps as its repeat count.
- R3: A couplet repeat of 0 and a block repeat of 0 both behave as 1.
- R4: A block's couplets are emitted in program order, and the whole group is emitted as many times as the block repeat count.
- R5: End actions are encoded as follows: 00 halts, 01 continues with the header right after the couplets, 10 restarts at address 0, and 11 jumps to address page×8192.
- R6: After the last step before a halt, `halted` is 1. No further `pix_ce` produces a step until `run` falls.
- R7: Pixel codes are 0 ignore, 1 vsync, 2 hsync, 3 valid pixel and 4 overclock. `seq_data` is 1 on a step only for codes 3 and 4.
- R8: With `pix_ce` pulses at least 10 cycles apart, every step comes from the program and no filler appears between couplets or blocks. A pulse that arrives before any couplet is ready gives a filler step with SRAM address 0 and code 0.
- R9: A word whose tag does not match its position sets `fmt_err` and stops fetching. Couplets that come earlier in program order still execute, after which `halted` is 1.
- R10: A block with couplet count 0 emits no steps and takes its end action at once.
- R11: While `run` is 0 (and after reset) no steps are emitted and `halted` and `fmt_err` are 0. The next rise of `run` restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 runs the program; 0 returns to idle |
| pix_ce | input | 1 | Pixel clock enable, one cycle per pixel clock |
| mem_addr | output | 15 | Program memory read address |
| mem_rdata | input | 16 | Program memory data, one cycle after the address |
| seq_stb | output | 1 | One-cycle pulse marking a step |
| seq_sram | output | 11 | SRAM block address of the step |
| seq_code | output | 3 | Pixel code of the step |
| seq_data | output | 1 | Step carries valid pixel or overclock data |
| halted | output | 1 | Program stopped and all fetched couplets emitted |
| fmt_err | output | 1 | A word with a wrong tag was met |

## Verification
The programs exercise several distinct patterns:
- A single block with mixed repeats, including a zero repeat, which separates per-couplet counting from block counting.
- A two-block chain in which the first block repeats, which shows whether the group is re-fetched from its first couplet and whether the couplet order holds.
- A self-restarting loop, a jump into page 2 and a zero-couplet block, which distinguish the four end actions and the empty-block path.
- Malformed words at a header slot and at a couplet slot, and an early pixel clock right after start, which cover the error drain and the filler step.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    // Program word layout (fixed by the word format)
    localparam int WORD_W = 16;
    localparam int SRAM_W = 11;
    localparam int CODE_W = 3;
    localparam int CREP_W = 14;
    localparam int BREP_W = 12;
    localparam int CCNT_W = 12;

    localparam logic [1:0] TAG_HDR_A = 2'b11;
    localparam logic [1:0] TAG_HDR_B = 2'b10;
    localparam logic [1:0] TAG_CPL_A = 2'b01;
    localparam logic [1:0] TAG_CPL_B = 2'b00;

    localparam logic [CODE_W-1:0] CODE_IGNORE = 3'd0;
    localparam logic [CODE_W-1:0] CODE_VSYNC  = 3'd1;
    localparam logic [CODE_W-1:0] CODE_HSYNC  = 3'd2;
    localparam logic [CODE_W-1:0] CODE_VALID  = 3'd3;
    localparam logic [CODE_W-1:0] CODE_OVCLK  = 3'd4;

    typedef enum logic [1:0] {
        END_HALT    = 2'd0,
        END_NEXT    = 2'd1,
        END_RESTART = 2'd2,
        END_JUMP    = 2'd3
    } end_act_e;

    typedef struct packed {
        logic [SRAM_W-1:0] sram;
        logic [CODE_W-1:0] code;
        logic [CREP_W-1:0] rep;
    } cpl_t;

endpackage

// File: rtl/ccd_seq_fetch.sv
module ccd_seq_fetch
    import ccd_seq_pkg::*;
#(
    parameter int PAGE_W     = 2,
    parameter int PAGE_OFS_W = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    output logic [PAGE_W+PAGE_OFS_W-1:0] mem_addr,
    input  logic [WORD_W-1:0]            mem_rdata,
    input  logic                         nxt_take,
    output logic                         nxt_v,
    output cpl_t                         nxt,
    output logic                         stopped,
    output logic                         fmt_err
);

    localparam int ADDR_W = PAGE_W + PAGE_OFS_W;

    typedef enum logic [2:0] {
        F_IDLE, F_H0, F_H1, F_C0, F_C1, F_STOP
    } fstate_e;

    typedef struct packed {
        fstate_e            st;
        logic               ph;      // 0: address issued, 1: data present
        logic [ADDR_W-1:0]  pc;
        logic [ADDR_W-1:0]  first;   // first couplet of current block
        logic [BREP_W-1:0]  blk_left;
        logic [CCNT_W-1:0]  cnt;
        logic [CCNT_W-1:0]  cleft;
        end_act_e           act;
        logic [PAGE_W-1:0]  page;
        logic [SRAM_W-1:0]  hold_sram;
        logic [CODE_W-1:0]  hold_code;
        cpl_t               nxt;
        logic               nxt_v;
        logic               err;
    } fetch_s;

    fetch_s q, d;
    logic [1:0] tag;
    logic       finish;
    logic       bad;

    always_comb begin
        d      = q;
        tag    = mem_rdata[15:14];
        finish = 1'b0;
        bad    = 1'b0;
        if (nxt_take) d.nxt_v = 1'b0;

        unique case (q.st)
            F_IDLE: begin
                if (run) begin
                    d.st = F_H0;
                    d.ph = 1'b0;
                    d.pc = '0;
                end
            end
            F_H0: begin
                if (!q.ph) d.ph = 1'b1;
                else if (tag != TAG_HDR_A) bad = 1'b1;
                else begin
                    d.ph       = 1'b0;
                    d.act      = end_act_e'(mem_rdata[13:12]);
                    d.blk_left = (mem_rdata[11:0] == '0) ? BREP_W'(1) : mem_rdata[11:0];
                    d.pc       = q.pc + ADDR_W'(1);
                    d.st       = F_H1;
                end
            end
            F_H1: begin
                if (!q.ph) d.ph = 1'b1;
                else if (tag != TAG_HDR_B) bad = 1'b1;
                else begin
                    d.ph    = 1'b0;
                    d.page  = mem_rdata[13:12];
                    d.cnt   = mem_rdata[11:0];
                    d.cleft = mem_rdata[11:0];
                    d.pc    = q.pc + ADDR_W'(1);
                    d.first = q.pc + ADDR_W'(1);
                    if (mem_rdata[11:0] == '0) finish = 1'b1;
                    else d.st = F_C0;
                end
            end
            F_C0: begin
                if (!q.ph) begin
                    if (!q.nxt_v) d.ph = 1'b1;
                end else if (tag != TAG_CPL_A) bad = 1'b1;
                else begin
                    d.ph        = 1'b0;
                    d.hold_sram = mem_rdata[13:3];
                    d.hold_code = mem_rdata[2:0];
                    d.pc        = q.pc + ADDR_W'(1);
                    d.st        = F_C1;
                end
            end
            F_C1: begin
                if (!q.ph) d.ph = 1'b1;
                else if (tag != TAG_CPL_B) bad = 1'b1;
                else begin
                    d.ph       = 1'b0;
                    d.nxt.sram = q.hold_sram;
                    d.nxt.code = q.hold_code;
                    d.nxt.rep  = mem_rdata[13:0];
                    d.nxt_v    = 1'b1;
                    d.pc       = q.pc + ADDR_W'(1);
                    d.st       = F_C0;
                    if (q.cleft == CCNT_W'(1)) begin
                        if (q.blk_left > BREP_W'(1)) begin
                            d.blk_left = q.blk_left - BREP_W'(1);
                            d.pc       = q.first;
                            d.cleft    = q.cnt;
                        end else begin
                            finish = 1'b1;
                        end
                    end else begin
                        d.cleft = q.cleft - CCNT_W'(1);
                    end
                end
            end
            F_STOP: begin
                d.ph = 1'b0;
            end
            default: d.st = F_IDLE;
        endcase

        if (finish) begin
            unique case (d.act)
                END_HALT:    d.st = F_STOP;
                END_NEXT:    d.st = F_H0;
                END_RESTART: begin d.st = F_H0; d.pc = '0; end
                END_JUMP:    begin d.st = F_H0; d.pc = {d.page, {PAGE_OFS_W{1'b0}}}; end
                default:     d.st = F_STOP;
            endcase
        end

        if (bad) begin
            d.err = 1'b1;
            d.ph  = 1'b0;
            d.st  = F_STOP;
        end

        if (!run) begin
            d.st    = F_IDLE;
            d.ph    = 1'b0;
            d.pc    = '0;
            d.nxt_v = 1'b0;
            d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_addr = q.pc;
    assign nxt_v    = q.nxt_v;
    assign nxt      = q.nxt;
    assign stopped  = (q.st == F_STOP);
    assign fmt_err  = q.err;

endmodule

// File: rtl/ccd_seq_exec.sv
module ccd_seq_exec
    import ccd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pix_ce,
    input  logic              nxt_v,
    input  cpl_t              nxt,
    input  logic              fetch_stopped,
    output logic              nxt_take,
    output logic              seq_stb,
    output logic [SRAM_W-1:0] seq_sram,
    output logic [CODE_W-1:0] seq_code,
    output logic              seq_data,
    output logic              halted
);

    typedef struct packed {
        logic [CREP_W-1:0] left;    // steps still owed by current couplet
        logic [SRAM_W-1:0] cur_sram;
        logic [CODE_W-1:0] cur_code;
        logic              stb;
        logic [SRAM_W-1:0] o_sram;
        logic [CODE_W-1:0] o_code;
        logic              o_data;
    } exec_s;

    exec_s q, d;
    logic  drained;

    always_comb begin
        d        = q;
        d.stb    = 1'b0;
        nxt_take = 1'b0;
        drained  = fetch_stopped && !nxt_v && (q.left == '0);

        if (run && pix_ce && !drained) begin
            d.stb = 1'b1;
            if (q.left != '0) begin
                d.o_sram = q.cur_sram;
                d.o_code = q.cur_code;
                d.left   = q.left - CREP_W'(1);
            end else if (nxt_v) begin
                nxt_take   = 1'b1;
                d.o_sram   = nxt.sram;
                d.o_code   = nxt.code;
                d.cur_sram = nxt.sram;
                d.cur_code = nxt.code;
                d.left     = (nxt.rep == '0) ? '0 : nxt.rep - CREP_W'(1);
            end else begin
                d.o_sram = '0;
                d.o_code = CODE_IGNORE;
            end
            d.o_data = (d.o_code == CODE_VALID) || (d.o_code == CODE_OVCLK);
        end

        if (!run) begin
            d.left = '0;
            d.stb  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign seq_stb  = q.stb;
    assign seq_sram = q.o_sram;
    assign seq_code = q.o_code;
    assign seq_data = q.o_data;
    assign halted   = run && drained;

endmodule

// File: rtl/ccd_prog_seq.sv
module ccd_prog_seq
    import ccd_seq_pkg::*;
#(
    parameter int PAGE_W     = 2,
    parameter int PAGE_OFS_W = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic                         pix_ce,
    output logic [PAGE_W+PAGE_OFS_W-1:0] mem_addr,
    input  logic [WORD_W-1:0]            mem_rdata,
    output logic                         seq_stb,
    output logic [SRAM_W-1:0]            seq_sram,
    output logic [CODE_W-1:0]            seq_code,
    output logic                         seq_data,
    output logic                         halted,
    output logic                         fmt_err
);

    logic nxt_take;
    logic nxt_v;
    cpl_t nxt;
    logic fetch_stopped;

    ccd_seq_fetch #(
        .PAGE_W     (PAGE_W),
        .PAGE_OFS_W (PAGE_OFS_W)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .nxt_take  (nxt_take),
        .nxt_v     (nxt_v),
        .nxt       (nxt),
        .stopped   (fetch_stopped),
        .fmt_err   (fmt_err)
    );

    ccd_seq_exec u_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .pix_ce        (pix_ce),
        .nxt_v         (nxt_v),
        .nxt           (nxt),
        .fetch_stopped (fetch_stopped),
        .nxt_take      (nxt_take),
        .seq_stb       (seq_stb),
        .seq_sram      (seq_sram),
        .seq_code      (seq_code),
        .seq_data      (seq_data),
        .halted        (halted)
    );

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk
    import ccd_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              pix_ce,
    input logic              seq_stb,
    input logic [CODE_W-1:0] seq_code,
    input logic              seq_data,
    input logic              halted,
    input logic              fmt_err
);

    AST_STEP_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_stb |-> ($past(pix_ce) && $past(run)));                         // R2

    AST_HALT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && pix_ce) |=> !seq_stb);                                   // R6

    AST_DATA_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_stb && seq_data) |-> (seq_code == CODE_VALID || seq_code == CODE_OVCLK)); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_err && run) |=> fmt_err);                                      // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!seq_stb && !halted && !fmt_err));                        // R11

endmodule

bind ccd_prog_seq ccd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pix_ce   (pix_ce),
    .seq_stb  (seq_stb),
    .seq_code (seq_code),
    .seq_data (seq_data),
    .halted   (halted),
    .fmt_err  (fmt_err)
);

// File: tb/ccd_prog_seq_tb_top.sv
module ccd_prog_seq_tb_top;
    import ccd_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        pix_ce = 1'b0;
    logic [14:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        seq_stb;
    logic [10:0] seq_sram;
    logic [2:0]  seq_code;
    logic        seq_data;
    logic        halted;
    logic        fmt_err;

    always #5 clk = ~clk;

    ccd_prog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .pix_ce(pix_ce),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .seq_stb(seq_stb), .seq_sram(seq_sram), .seq_code(seq_code),
        .seq_data(seq_data), .halted(halted), .fmt_err(fmt_err)
    );

    // sparse program memory: 64 words at the base of each page
    logic [15:0] mem [0:255];
    always @(posedge clk) mem_rdata <= mem[{mem_addr[14:13], mem_addr[5:0]}];

    typedef struct {
        logic [10:0] sram;
        logic [2:0]  code;
        logic        data;
    } step_t;

    step_t expq[$];
    step_t mon_e;
    int    checks = 0;
    int    errors = 0;
    int    steps_seen = 0;
    string cur_req = "R2";
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] hdr_a(input logic [1:0] act, input int rep);
        return {TAG_HDR_A, act, rep[11:0]};
    endfunction
    function automatic logic [15:0] hdr_b(input logic [1:0] page, input int cnt);
        return {TAG_HDR_B, page, cnt[11:0]};
    endfunction
    function automatic logic [15:0] cpl_a(input int sram, input logic [2:0] code);
        return {TAG_CPL_A, sram[10:0], code};
    endfunction
    function automatic logic [15:0] cpl_b(input int rep);
        return {TAG_CPL_B, rep[13:0]};
    endfunction

    task automatic wr(input int page, input int ofs, input logic [15:0] w);
        mem[{page[1:0], ofs[5:0]}] = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    // driver side of the scoreboard
    task automatic expect_steps(input int sram, input logic [2:0] code, input int n);
        step_t e;
        e.sram = sram[10:0];
        e.code = code;
        e.data = (code == CODE_VALID) || (code == CODE_OVCLK);
        for (int i = 0; i < n; i++) expq.push_back(e);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pix_ce = 1'b1;
            @(negedge clk) pix_ce = 1'b0;
            repeat (10) @(negedge clk);
        end
    endtask

    task automatic start_run();
        @(negedge clk) run = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk) run = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic drained(input string req);
        chk(expq.size() == 0, req, "expected steps left", expq.size(), 0);
        expq.delete();
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && seq_stb) begin
            steps_seen++;
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL %s unexpected step: actual sram=%0d code=%0d expected none",
                         cur_req, seq_sram, seq_code);
            end else begin
                mon_e = expq.pop_front();
                chk(seq_sram == mon_e.sram && seq_code == mon_e.code && seq_data == mon_e.data,
                    cur_req, "step {sram,code,data}",
                    {seq_sram, seq_code, seq_data}, {mon_e.sram, mon_e.code, mon_e.data});
            end
        end
    end

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        int seen0;
        clear_mem();
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(seq_stb == 1'b0, "R11", "stb at reset", seq_stb, 0);
        chk(halted == 1'b0, "R11", "halted at reset", halted, 0);
        chk(fmt_err == 1'b0, "R11", "fmt_err at reset", fmt_err, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // T1: one halting block, mixed repeats; early pulse gives filler (R8, R3, R1)
        cur_req = "R2_R3_R8";
        wr(0, 0, hdr_a(END_HALT, 1));
        wr(0, 1, hdr_b(0, 2));
        wr(0, 2, cpl_a(5, CODE_VALID));
        wr(0, 3, cpl_b(3));
        wr(0, 4, cpl_a(6, CODE_OVCLK));
        wr(0, 5, cpl_b(0));
        expect_steps(0, CODE_IGNORE, 1);
        @(negedge clk) run = 1'b1;
        @(negedge clk) pix_ce = 1'b1;
        @(negedge clk) pix_ce = 1'b0;
        repeat (24) @(negedge clk);
        expect_steps(5, CODE_VALID, 3);
        expect_steps(6, CODE_OVCLK, 1);
        pulses(4);
        drained("R2");
        chk(halted == 1'b1, "R6", "halted after last step", halted, 1);
        cur_req = "R6";
        seen0 = steps_seen;
        pulses(2);
        chk(steps_seen == seen0, "R6", "steps while halted", steps_seen - seen0, 0);
        stop_run();
        chk(halted == 1'b0, "R11", "halted cleared by run low", halted, 0);

        // T2: repeated block then block with zero repeat (R4, R3, R5 continue, R7)
        cur_req = "R4_R7";
        clear_mem();
        wr(0, 0, hdr_a(END_NEXT, 2));
        wr(0, 1, hdr_b(0, 2));
        wr(0, 2, cpl_a(7, CODE_VSYNC));
        wr(0, 3, cpl_b(1));
        wr(0, 4, cpl_a(8, CODE_VALID));
        wr(0, 5, cpl_b(2));
        wr(0, 6, hdr_a(END_HALT, 0));
        wr(0, 7, hdr_b(0, 1));
        wr(0, 8, cpl_a(9, CODE_HSYNC));
        wr(0, 9, cpl_b(1));
        start_run();
        expect_steps(7, CODE_VSYNC, 1);
        expect_steps(8, CODE_VALID, 2);
        expect_steps(7, CODE_VSYNC, 1);
        expect_steps(8, CODE_VALID, 2);
        expect_steps(9, CODE_HSYNC, 1);
        pulses(7);
        drained("R4");
        chk(halted == 1'b1, "R5", "halted after continue chain", halted, 1);
        stop_run();

        // T3: restart loop runs forever until run drops (R5 restart, R11)
        cur_req = "R5_restart";
        clear_mem();
        wr(0, 0, hdr_a(END_RESTART, 1));
        wr(0, 1, hdr_b(0, 1));
        wr(0, 2, cpl_a(3, CODE_IGNORE));
        wr(0, 3, cpl_b(2));
        start_run();
        expect_steps(3, CODE_IGNORE, 9);
        pulses(9);
        drained("R5");
        chk(halted == 1'b0, "R5", "restart loop not halted", halted, 0);
        stop_run();
        cur_req = "R11";
        seen0 = steps_seen;
        pulses(2);
        chk(steps_seen == seen0, "R11", "steps while run low", steps_seen - seen0, 0);

        // T4: jump to page 2 (R5 jump)
        cur_req = "R5_jump";
        clear_mem();
        wr(0, 0, hdr_a(END_JUMP, 1));
        wr(0, 1, hdr_b(2, 1));
        wr(0, 2, cpl_a(1, CODE_VALID));
        wr(0, 3, cpl_b(1));
        wr(2, 0, hdr_a(END_HALT, 1));
        wr(2, 1, hdr_b(0, 1));
        wr(2, 2, cpl_a(2, CODE_OVCLK));
        wr(2, 3, cpl_b(2));
        start_run();
        expect_steps(1, CODE_VALID, 1);
        expect_steps(2, CODE_OVCLK, 2);
        pulses(3);
        drained("R5");
        chk(halted == 1'b1, "R5", "halted on page 2", halted, 1);
        stop_run();

        // T5: zero-couplet block (R10)
        cur_req = "R10";
        clear_mem();
        wr(0, 0, hdr_a(END_NEXT, 3));
        wr(0, 1, hdr_b(0, 0));
        wr(0, 2, hdr_a(END_HALT, 1));
        wr(0, 3, hdr_b(0, 1));
        wr(0, 4, cpl_a(4, CODE_VALID));
        wr(0, 5, cpl_b(1));
        start_run();
        expect_steps(4, CODE_VALID, 1);
        pulses(2);
        drained("R10");
        chk(halted == 1'b1, "R10", "halted after empty block", halted, 1);
        stop_run();

        // T6: bad tag at a header slot; earlier couplets still run (R9)
        cur_req = "R9";
        clear_mem();
        wr(0, 0, hdr_a(END_NEXT, 1));
        wr(0, 1, hdr_b(0, 1));
        wr(0, 2, cpl_a(5, CODE_VALID));
        wr(0, 3, cpl_b(2));
        wr(0, 4, cpl_a(9, CODE_VALID));
        start_run();
        expect_steps(5, CODE_VALID, 2);
        pulses(4);
        drained("R9");
        chk(fmt_err == 1'b1, "R9", "fmt_err on header slot", fmt_err, 1);
        chk(halted == 1'b1, "R9", "halted after error drain", halted, 1);
        stop_run();
        chk(fmt_err == 1'b0, "R11", "fmt_err cleared by run low", fmt_err, 0);

        // T7: bad tag at a couplet slot, nothing emitted (R9)
        clear_mem();
        wr(0, 0, hdr_a(END_HALT, 1));
        wr(0, 1, hdr_b(0, 1));
        wr(0, 2, hdr_a(END_HALT, 1));
        start_run();
        seen0 = steps_seen;
        pulses(2);
        chk(steps_seen == seen0, "R9", "steps after bad couplet", steps_seen - seen0, 0);
        chk(fmt_err == 1'b1, "R9", "fmt_err on couplet slot", fmt_err, 1);
        stop_run();

        finish_sim();
    end

endmodule